// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that a host reads and loads over a small register bus. It counts one of two sources. The first is the instruction-cycle tick, a one-cycle enable pulse on the system clock. The second is edges of an external pin, taken on the rising or the falling edge as chosen. The external pin is first resynchronized by two flip-flops, and its edges are then detected on the system clock, so the whole design runs in one clock domain.

A single 8-bit prescaler divides the count events. A routing bit lends the prescaler either to the counter or to a watchdog tick path. The watchdog timeout counter itself lives outside this block. When the prescaler serves the watchdog, the counter takes every event undivided, and the block emits the divided watchdog tick on `wdt_tick`.

When the counter wraps from 8'hFF to 8'h00, a sticky flag is set. An enable bit gates that flag onto the interrupt output. Loading the count register blocks counting for the next two instruction cycles and restarts the prescaler.

The register map uses `bus_addr`:
- Address 0: the count.
- Address 1: the control register. Bits 2:0 are the ratio select, bit 3 routes the prescaler (1 = watchdog), bit 4 selects the falling edge, and bit 5 selects the external source.
- Address 2: status. Bit 0 is the flag and bit 1 is the interrupt enable.

Reads are combinational, and writes take effect at the clock edge that samples `bus_wr`. All pins are plain level or pulse signals, with no back-pressure.

Top module: `tmr8_timer`

## Requirements
- R1: After reset, the count (address 0) reads 8'h00, the control register (address 1) reads 8'h08, status (address 2) reads 8'h00 and `irq` is low. A write to address 0 loads the count, which then reads back the written value.
- R2: With control bit 5 clear, the count advances by one per `cyc_tick` pulse. With bit 5 set, it advances on edges of `ext_pin`, and `cyc_tick` pulses do not advance it.
- R3: With control bit 4 clear, rising edges of `ext_pin` are counted. With bit 4 set, only falling edges are counted.
- R4: After a write to the count, the next two `cyc_tick` pulses advance neither the count nor the prescaler. A `cyc_tick` in the same cycle as the write is lost, and the written value is kept.
- R5: A wrap from 8'hFF to 8'h00 sets the flag (status bit 0).
- R6: `irq` equals the flag ANDed with status bit 1. The flag stays set until a status write with bit 0 at 0; a status write with bit 0 at 1 leaves the flag unchanged.
- R7: If a status write clearing the flag and a wrap fall in the same cycle, the flag ends set.
- R8: With control bit 3 clear, the counter advances once per 2^(PS+1) source events, where PS is control bits 2:0. Any write to the count or to the control register restarts that division.
- R9: With control bit 3 set, the counter takes every source event and `wdt_tick` pulses once per 2^PS `wdt_base_tick` pulses. With bit 3 clear, `wdt_tick` follows `wdt_base_tick` one for one.
- R10: A change of `ext_pin` first sampled at clock edge k changes the count at clock edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cyc_tick | input | 1 | Instruction-cycle enable pulse |
| ext_pin | input | 1 | External count input, asynchronous |
| wdt_base_tick | input | 1 | Undivided watchdog base tick |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Watchdog tick after optional division |

## Verification
A register write or an internal tick is visible one clock after the edge that samples it. An external pin change is visible on the third edge after it is driven: two synchronizer stages, then the counter. `irq` and `wdt_tick` follow combinationally from registered state.

The bench drives every input on the falling clock edge and reads on a later falling edge, after the needed number of rising edges has passed. For the synchronizer, it reads once after two rising edges, expecting no change, and again after the third. Expected counts under the prescaler are computed from the ratio, minus the two inhibited ticks.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic             ext_src;
    logic             fall_edge;
    logic             pre_to_wdt;
    logic [SEL_W-1:0] ratio_sel;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
  localparam tmr_ctrl_t CTRL_RST = '{ext_src: 1'b0, fall_edge: 1'b0,
                                     pre_to_wdt: 1'b1, ratio_sel: '0};

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_evt
);
  // stages 0..STAGES-1 synchronize, the last one holds the previous level
  logic [STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise     = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall     = ~sh_q[STAGES-1] & sh_q[STAGES];
  assign edge_evt = fall_sel ? fall : rise;

  // R10
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_tick,
  input  logic             long_mode,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  logic [PRE_W-1:0] pc_q;
  logic [SEL_W:0]   shamt;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] mask;

  always_comb begin
    shamt   = {1'b0, sel} + {{SEL_W{1'b0}}, long_mode};
    one_hot = (PRE_W+1)'(1) << shamt;
    mask    = one_hot[PRE_W-1:0] - PRE_W'(1);
  end

  assign out_tick = in_tick && ((pc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) pc_q <= '0;
    else if (in_tick)  pc_q <= pc_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int CNT_W     = 8,
  parameter int INH_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             cnt_evt,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q,
  output logic             inh_busy
);
  localparam int INH_W = $clog2(INH_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [INH_W-1:0] inh_q;
  logic             do_inc, wrap;

  assign inh_busy = (inh_q != '0);
  assign do_inc   = cnt_evt && !cnt_wr;
  assign wrap     = do_inc && (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      inh_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_wr)      count_q <= wdata;
      else if (do_inc) count_q <= count_q + CNT_W'(1);

      if (cnt_wr)                    inh_q <= INH_W'(INH_TICKS);
      else if (cyc_tick && inh_busy) inh_q <= inh_q - INH_W'(1);

      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));
  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_busy && !cnt_wr) |=> count_q == $past(count_q));
  // R5
  flag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (count_q == '0 && $past(count_q) == CNT_MAX));
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INH_TICKS   = 2,
  parameter int PRE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              ext_pin,
  input  logic              wdt_base_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wdt_tick
);
  tmr_ctrl_t        ctrl_q;
  logic             ie_q, flag_q, inh_busy;
  logic             wr_cnt, wr_ctrl, wr_stat;
  logic             edge_evt, src_evt, gated_evt, pre_in, pre_out, cnt_evt;
  logic [CNT_W-1:0] count_q;

  assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ie_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_stat) ie_q   <= bus_wdata[1];
    end
  end

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_sel(ctrl_q.fall_edge), .edge_evt(edge_evt));

  assign src_evt   = ctrl_q.ext_src ? edge_evt : cyc_tick;
  assign gated_evt = src_evt && !inh_busy;
  assign pre_in    = ctrl_q.pre_to_wdt ? wdt_base_tick : gated_evt;

  tmr8_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_cnt || wr_ctrl), .in_tick(pre_in),
    .long_mode(!ctrl_q.pre_to_wdt), .sel(ctrl_q.ratio_sel), .out_tick(pre_out));

  assign cnt_evt  = ctrl_q.pre_to_wdt ? gated_evt : pre_out;
  assign wdt_tick = ctrl_q.pre_to_wdt ? pre_out : wdt_base_tick;

  tmr8_core #(.CNT_W(CNT_W), .INH_TICKS(INH_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cnt_evt(cnt_evt),
    .cnt_wr(wr_cnt), .wdata(bus_wdata), .flag_clr(wr_stat && !bus_wdata[0]),
    .count_q(count_q), .flag_q(flag_q), .inh_busy(inh_busy));

  assign irq = flag_q && ie_q;

  always_comb begin
    case (bus_addr)
      A_COUNT:  bus_rdata = count_q;
      A_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_STATUS: bus_rdata = {{(CNT_W-2){1'b0}}, ie_q, flag_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R8
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !ctrl_q.pre_to_wdt && !wr_ctrl) |=> !cnt_evt);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[1]) |=> !irq);
endmodule

// File: tb/tmr8_timer_test.sv
module tmr8_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0, ext_pin = 1'b0, wdt_base_tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, wdt_tick;
  int n_run = 0, n_fail = 0, wdt_seen = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  tmr8_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .wdt_base_tick(wdt_base_tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_tick(wdt_tick));

  always @(posedge clk) if (wdt_tick) wdt_seen++;

  // ctrl[31:24], tick count[23:8], expected count[7:0]
  localparam logic [31:0] VECS [0:6] = '{
    {8'h08, 16'd10,  8'd8},
    {8'h00, 16'd12,  8'd5},
    {8'h01, 16'd18,  8'd4},
    {8'h02, 16'd26,  8'd3},
    {8'h03, 16'd50,  8'd3},
    {8'h07, 16'd261, 8'd1},
    {8'h0F, 16'd7,   8'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_tick = 1'b1;
      @(negedge clk); cyc_tick = 1'b0;
    end
  endtask

  task automatic base_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_base_tick = 1'b1;
      @(negedge clk); wdt_base_tick = 1'b0;
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pin_pulse();
    @(negedge clk); ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd0, v); check("R1 reset count", v, 8'h00);
    peek(2'd1, v); check("R1 reset ctrl", v, 8'h08);
    peek(2'd2, v); check("R1 reset status", v, 8'h00);
    check("R1 reset irq", irq, 0);

    bus_write(2'd0, 8'h5A);
    peek(2'd0, v); check("R1 count load", v, 8'h5A);

    // prescaler ratio table (R8, R9 timer side, R2 internal source)
    for (int i = 0; i < 7; i++) begin
      bus_write(2'd1, VECS[i][31:24]);
      bus_write(2'd0, 8'h00);
      ticks(int'(VECS[i][23:8]));
      @(negedge clk); peek(2'd0, v);
      check($sformatf("R8 ratio vec %0d", i), v, VECS[i][7:0]);
    end

    // R4 inhibit after a write
    bus_write(2'd1, 8'h08);
    bus_write(2'd0, 8'h10);
    ticks(2); peek(2'd0, v); check("R4 inhibited ticks", v, 8'h10);
    ticks(1); peek(2'd0, v); check("R4 first counted tick", v, 8'h11);
    // R4 write and tick in the same cycle
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40; cyc_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cyc_tick = 1'b0;
    ticks(2); peek(2'd0, v); check("R4 collision keeps write", v, 8'h40);
    ticks(1); peek(2'd0, v); check("R4 collision then count", v, 8'h41);

    // R5 / R6 wrap, flag and interrupt
    bus_write(2'd0, 8'hFE);
    ticks(3); peek(2'd2, v); check("R5 no flag at FF", v, 8'h00);
    ticks(1); peek(2'd0, v); check("R5 wrap to 00", v, 8'h00);
    peek(2'd2, v); check("R5 flag set", v, 8'h01);
    check("R6 irq masked", irq, 0);
    bus_write(2'd2, 8'h03);
    peek(2'd2, v); check("R6 write 1 keeps flag", v, 8'h03);
    check("R6 irq raised", irq, 1);
    bus_write(2'd2, 8'h02);
    peek(2'd2, v); check("R6 flag cleared", v, 8'h02);
    check("R6 irq dropped", irq, 0);

    // R7 clear and wrap together
    bus_write(2'd0, 8'hFF);
    ticks(2);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h02; cyc_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cyc_tick = 1'b0;
    peek(2'd2, v); check("R7 wrap beats clear", v, 8'h03);
    check("R7 irq", irq, 1);
    bus_write(2'd2, 8'h00);

    // R9 watchdog division
    bus_write(2'd1, 8'h0A);
    wdt_seen = 0; base_ticks(8); @(negedge clk);
    check("R9 wdt divided by 4", wdt_seen, 2);
    bus_write(2'd1, 8'h00);
    wdt_seen = 0; base_ticks(3); @(negedge clk);
    check("R9 wdt passthrough", wdt_seen, 3);

    // R2 / R10 external rising edges
    bus_write(2'd1, 8'h28);
    bus_write(2'd0, 8'h00);
    ticks(5); peek(2'd0, v); check("R2 ticks ignored in ext mode", v, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(2'd0, v); check("R10 not before edge k+2", v, 8'h00);
    @(negedge clk);
    peek(2'd0, v); check("R10 counted at edge k+2", v, 8'h01);
    repeat (3) @(negedge clk); ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    pin_pulse(); pin_pulse();
    peek(2'd0, v); check("R3 rising edges", v, 8'h03);

    // R3 falling edges
    bus_write(2'd1, 8'h38);
    bus_write(2'd0, 8'h00);
    ticks(2);
    @(negedge clk); ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd0, v); check("R3 rise ignored in fall mode", v, 8'h00);
    ext_pin = 1'b0; repeat (4) @(negedge clk);
    pin_pulse();
    peek(2'd0, v); check("R3 falling edges", v, 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule